// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a small supervisory timer. It counts strobes from a slow prescaler tick and, when the count reaches its expiry value, asks the system for a reset. Software keeps the system alive by writing two key bytes to the block's single register. The first byte arms a tracker and the second byte clears the count. Any other write breaks the sequence, so a runaway program that happens to write the register is unlikely to keep the timer quiet by accident.

Reading the register returns the live count. A separate enable input decides whether expiry may actually produce a reset request. While that input is low, the count parks at its expiry value until software clears it or the enable goes high. The number of prescaler strobes per count step is a parameter, which sets the effective timeout.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the count reads 0, `rst_req_o` is 0 and the key tracker is in its idle state, so a lone 0x03 write has no effect.
- R2: The count advances by exactly one for every `TICK_DIV` strobes on `tick_i`. It appears on `rd_data_o[3:0]` with `rd_data_o[7:4]` always 0, and it never exceeds 8.
- R3: A write of 0x0A followed by the very next write being 0x03 returns the count to 0 on the edge of the 0x03 write. It also restarts the strobe divider.
- R4: A write of 0x03 takes effect only when the previous write was 0x0A. Any other value written between 0x0A and 0x03 cancels the clear, and the count is left untouched.
- R5: Writing 0x0A while the tracker is already armed keeps it armed, so 0x0A, 0x0A, 0x03 still clears the count.
- R6: When the count holds 8 and `rst_en_i` is 1, the next clock edge raises `rst_req_o` for exactly one cycle and returns the count to 0.
- R7: While `rst_en_i` is 0, a count of 8 holds, further strobes are ignored and `rst_req_o` stays 0. Raising `rst_en_i` fires the request on the following edge.
- R8: A key clear wins over a strobe in the same cycle. An expiry with `rst_en_i` high wins over a key clear in the same cycle, so the request still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle prescaler strobe |
| rst_en_i | input | 1 | Allows expiry to produce a reset request |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data (key bytes) |
| rd_data_o | output | 8 | Register read value: count in bits 3:0 |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
The assertions check on every cycle that the count stays within 0 to 8 with zero upper bits, and that it only holds, steps by one or returns to 0. They also check that a request lasts one cycle and coincides with a zero count, and that a parked count with the enable low stays parked when no write arrives. Whether a particular write sequence clears or fails to clear depends on the order of the key bytes. The bench's scenarios show this, together with the two priority collisions, by comparing the ports against a behavioural model on every clock.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  parameter int LIMIT    = 8,
  parameter int TICK_DIV = 1,
  parameter logic [DATA_W-1:0] KEY_ARM  = 'h0A,
  parameter logic [DATA_W-1:0] KEY_FIRE = 'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rst_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rst_req_o
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             req_q;
  logic             step;

  wire expired = (cnt == LIMIT_V);
  wire fire    = expired && rst_en_i;
  wire key_ok  = wr_en_i && armed && (wr_data_i == KEY_FIRE);
  wire restart = fire || key_ok;

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] DIV_TOP = DW'(TICK_DIV - 1);
      logic [DW-1:0] div;
      always_ff @(posedge clk) begin
        if (!rst_n)       div <= '0;
        else if (restart) div <= '0;
        else if (tick_i)  div <= (div == DIV_TOP) ? '0 : div + DW'(1);
      end
      assign step = tick_i && (div == DIV_TOP);
    end else begin : g_nodiv
      assign step = tick_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b0;
    else if (wr_en_i) armed <= (wr_data_i == KEY_ARM);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart)           cnt <= '0;
    else if (step && !expired)  cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= fire;
  end

  assign rd_data_o = {{(DATA_W-CNT_W){1'b0}}, cnt};
  assign rst_req_o = req_q;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int LIMIT  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_en_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rst_req_o
);
  wire [CNT_W-1:0] c = rd_data_o[CNT_W-1:0];

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c <= CNT_W'(LIMIT)) && (rd_data_o[DATA_W-1:CNT_W] == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (c == $past(c)) || (c == $past(c) + CNT_W'(1)) || (c == '0));

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_zero_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (c == '0));

  p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (c == CNT_W'(LIMIT) && !rst_en_i && !wr_en_i) |=> (c == CNT_W'(LIMIT)) && !rst_req_o);
endmodule

bind keyed_wdt keyed_wdt_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_en_i(rst_en_i), .wr_en_i(wr_en_i),
  .rd_data_o(rd_data_o), .rst_req_o(rst_req_o)
);

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/1ps
module keyed_wdt_bench;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       rst_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       rst_req_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_wdt #(.TICK_DIV(DIV)) u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rst_en_i(rst_en_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .rst_req_o(rst_req_o)
  );

  int m_cnt = 0, m_div = 0;
  bit m_armed = 0, m_req = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_armed = 0; m_req = 0;
    end else begin
      bit fire, keyok, stp;
      fire  = (m_cnt == 8) && rst_en_i;
      keyok = wr_en_i && m_armed && (wr_data_i == 8'h03);
      stp   = tick_i && (m_div == DIV - 1);
      if (fire || keyok) m_div = 0;
      else if (tick_i)   m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
      if (fire || keyok)           m_cnt = 0;
      else if (stp && m_cnt != 8)  m_cnt = m_cnt + 1;
      if (wr_en_i) m_armed = (wr_data_i == 8'h0A);
      m_req = fire;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (rd_data_o !== 8'(m_cnt) || rst_req_o !== m_req) begin
        bad++;
        $display("FAIL R2/R6 model: rd=%0d req=%0b expected rd=%0d req=%0b",
                 rd_data_o, rst_req_o, m_cnt, m_req);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", rd_data_o, 0);
    chk("R1 req", rst_req_o, 0);
    ticks(2);
    wr(8'h03);
    chk("R1 idle tracker", rd_data_o, 1);
    ticks(4);
    chk("R2 count", rd_data_o[3:0], 3);
    chk("R2 upper", rd_data_o[7:4], 0);
    wr(8'h0A); wr(8'h03);
    chk("R3 clear", rd_data_o, 0);
    ticks(4);
    wr(8'h0A); wr(8'h55); wr(8'h03);
    chk("R4 aborted", rd_data_o, 2);
    wr(8'h03);
    chk("R4 lone key", rd_data_o, 2);
    wr(8'h0A); wr(8'h0A); wr(8'h03);
    chk("R5 rearm", rd_data_o, 0);
    ticks(16);
    chk("R7 parked", rd_data_o, 8);
    ticks(4);
    repeat (3) @(negedge clk);
    chk("R7 hold", rd_data_o, 8);
    chk("R7 no req", rst_req_o, 0);
    rst_en_i = 1'b1;
    @(negedge clk);
    chk("R7 enable fires", rst_req_o, 1);
    chk("R6 count zero", rd_data_o, 0);
    @(negedge clk);
    chk("R6 single pulse", rst_req_o, 0);
    ticks(16);
    chk("R6 reached", rd_data_o, 8);
    @(negedge clk);
    chk("R6 req", rst_req_o, 1);
    chk("R6 restart", rd_data_o, 0);
    ticks(2);
    wr(8'h0A);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h03; tick_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; tick_i = 1'b0;
    chk("R8 clear beats tick", rd_data_o, 0);
    ticks(1);
    chk("R3 divider restart", rd_data_o, 0);
    ticks(1);
    chk("R3 divider step", rd_data_o, 1);
    rst_en_i = 1'b0;
    ticks(14);
    chk("R8 parked", rd_data_o, 8);
    wr(8'h0A);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'h03; rst_en_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0;
    chk("R8 expiry beats clear", rst_req_o, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule